// File: doc/BRIEF.md
# Per-Sector ECC Status Collector

This block gathers the decode outcome of every ECC sector in a flash page and presents the results as packed 32-bit status words. A separate BCH decoder hands it one sector result at a time. Each result carries a sector index, a 2-bit outcome and a 5-bit corrected-error count. The block stores an 8-bit field for each sector and packs four fields into each status word. It raises a sticky ECC interrupt flag whenever any sector reports a nonzero outcome. It also keeps a page summary: the worst correctable count seen and a sticky uncorrectable flag.

A page begins with a `page_start` pulse. The pulse latches the page-size code, which sets how many sectors the page holds and how many status words are live. Software or a sequencer then reads the words one index at a time through a combinational read port. The sector size is a parameter, given as a power of two in bytes. With the default of 512 bytes, the supported pages hold 2, 4, 8 or 16 sectors.

Top module: `sector_ecc_tracker`

## Requirements
- R1: A stored sector field holds the outcome in bits 1:0, the count in bits 6:2 and zero in bit 7. The field for sector n sits in byte (n mod 4) of status word (n div 4), where byte k means bits 8k+7:8k.
- R2: An accepted result with outcome 00 stores an all-zero field, whatever count it carries. Outcome 01 means correctable; 10 and 11 mean uncorrectable.
- R3: `page_code` is sampled on `page_start` and selects the page size: 00 is 1K, 01 is 2K, 10 is 4K and 11 is 8K. The sector count is the page size divided by the sector size (2, 4, 8 or 16 by default).
- R4: `live_words` equals the sector count divided by four, or 1 when there are fewer than four sectors. Reading a word index at or above `live_words` returns zero.
- R5: A result whose sector index is at or above the current sector count is ignored. It changes no field, no summary output and not the interrupt flag.
- R6: `irq_flag` is set in the cycle after an accepted result with a nonzero outcome. It stays set until `irq_clear` is 1. When a set and a clear fall in the same cycle, the set wins.
- R7: `max_correctable` is the largest count among accepted outcome-01 results since the last page start.
- R8: `page_uncorrectable` sets after an accepted result with outcome 10 or 11 and holds until the next page start.
- R9: `page_start` clears all fields, `max_correctable` and `page_uncorrectable`. A result presented in the same cycle is dropped. `irq_flag` is unaffected.
- R10: After reset, all status words, `irq_flag`, `max_correctable` and `page_uncorrectable` are zero, and the page code is 00.
- R11: A later accepted result for the same sector replaces that sector's earlier field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| page_start | input | 1 | Begin a new page: clear state, latch page code |
| page_code | input | 2 | Page-size code sampled on page_start |
| res_valid | input | 1 | Sector result present this cycle |
| res_sector | input | 4 | Sector index of the result |
| res_outcome | input | 2 | Decode outcome (00 clean, 01 corrected, 1x failed) |
| res_count | input | 5 | Number of corrected errors |
| irq_clear | input | 1 | Write-one clear of the interrupt flag |
| rd_word_idx | input | 2 | Status word index to read |
| rd_word | output | 32 | Packed status word (combinational) |
| live_words | output | 3 | Number of status words in use |
| irq_flag | output | 1 | Sticky ECC interrupt flag |
| max_correctable | output | 5 | Worst correctable count in this page |
| page_uncorrectable | output | 1 | Some sector failed in this page |

## Verification
The bench works the page-size boundaries. In the 1K page only two sectors exist, so word 0 is the single live word. A design that derived the word count without the floor of one would report zero live words or hide that word. Results aimed at sector indices just past the page end must leave every output unchanged. A design that compared against the maximum sector count instead would write stale fields and raise the interrupt. The bench also collides `irq_clear` with a new error, and `page_start` with a result, to catch designs that resolve either tie the wrong way. It feeds an outcome of 00 with a nonzero count to catch a design that stores the count anyway. A pseudo-random phase repeats results for the same sector, which exposes designs that merge fields instead of replacing them.

// File: rtl/ecc_stat_pkg.sv
package ecc_stat_pkg;

    localparam int FIELD_W         = 8;
    localparam int FIELDS_PER_WORD = 4;
    localparam int WORD_W          = FIELD_W * FIELDS_PER_WORD;
    localparam int COUNT_W         = 5;
    localparam int BASE_PAGE_LOG2  = 10;   // page code 00 is a 1K page

    typedef enum logic [1:0] {
        OUT_CLEAN = 2'b00,
        OUT_FIXED = 2'b01,
        OUT_BAD_A = 2'b10,
        OUT_BAD_B = 2'b11
    } ecc_outcome_e;

    // packed MSB first: rsvd is bit 7, nerr bits 6:2, outcome bits 1:0
    typedef struct packed {
        logic               rsvd;
        logic [COUNT_W-1:0] nerr;
        ecc_outcome_e       outcome;
    } sector_field_t;

    function automatic logic is_fixed(ecc_outcome_e o);
        return o == OUT_FIXED;
    endfunction

    function automatic logic is_bad(ecc_outcome_e o);
        return o[1];
    endfunction

    function automatic sector_field_t make_field(ecc_outcome_e o, logic [COUNT_W-1:0] n);
        sector_field_t f;
        f = '0;
        if (o != OUT_CLEAN) begin
            f.nerr    = n;
            f.outcome = o;
        end
        return f;
    endfunction

endpackage

// File: rtl/ecc_page_geometry.sv
module ecc_page_geometry
    import ecc_stat_pkg::*;
#(
    parameter int SECT_LOG2 = 9,
    parameter int SCNT_W    = 5,
    parameter int WIDX_W    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              page_start,
    input  logic [1:0]        page_code,
    output logic [SCNT_W-1:0] sector_count,
    output logic [WIDX_W:0]   live_words
);

    logic [1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst)             code_q <= 2'b00;
        else if (page_start) code_q <= page_code;
    end

    always_comb begin
        sector_count = SCNT_W'(1) << (BASE_PAGE_LOG2 + int'(code_q) - SECT_LOG2);
        if (sector_count < SCNT_W'(FIELDS_PER_WORD))
            live_words = (WIDX_W+1)'(1);
        else
            live_words = (WIDX_W+1)'(sector_count >> 2);
    end

    assert_live_words_R4: assert property (@(posedge clk) disable iff (rst)
        $countones(live_words) == 1);

endmodule

// File: rtl/ecc_status_bank.sv
module ecc_status_bank
    import ecc_stat_pkg::*;
#(
    parameter int MAX_SECTORS = 16,
    parameter int SIDX_W      = 4,
    parameter int WORDS       = 4,
    parameter int WIDX_W      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [SIDX_W-1:0] wr_idx,
    input  sector_field_t     wr_field,
    input  logic [WIDX_W-1:0] rd_idx,
    input  logic [WIDX_W:0]   live_words,
    output logic [WORD_W-1:0] rd_word
);

    sector_field_t     fields [MAX_SECTORS];
    logic [WORD_W-1:0] words  [WORDS];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            for (int i = 0; i < MAX_SECTORS; i++) fields[i] <= '0;
        end else if (wr_en) begin
            fields[wr_idx] <= wr_field;
        end
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        for (genvar b = 0; b < FIELDS_PER_WORD; b++) begin : g_byte
            assign words[g][FIELD_W*b +: FIELD_W] = fields[FIELDS_PER_WORD*g + b];
        end
    end

    always_comb begin
        if ({1'b0, rd_idx} < live_words) rd_word = words[rd_idx];
        else                             rd_word = '0;
    end

endmodule

// File: rtl/ecc_page_summary.sv
module ecc_page_summary
    import ecc_stat_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               accept,
    input  ecc_outcome_e       outcome,
    input  logic [COUNT_W-1:0] nerr,
    input  logic               irq_clear,
    output logic               irq_flag,
    output logic [COUNT_W-1:0] max_fixed,
    output logic               any_bad
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_flag <= 1'b0;
        end else if (accept && outcome != OUT_CLEAN) begin
            irq_flag <= 1'b1;
        end else if (irq_clear) begin
            irq_flag <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            max_fixed <= '0;
            any_bad   <= 1'b0;
        end else if (accept) begin
            if (is_fixed(outcome) && nerr > max_fixed) max_fixed <= nerr;
            if (is_bad(outcome)) any_bad <= 1'b1;
        end
    end

    assert_irq_set_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && outcome != OUT_CLEAN) |=> irq_flag);

    assert_irq_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !irq_clear) |=> irq_flag);

    assert_max_monotone_R7: assert property (@(posedge clk) disable iff (rst)
        !clear |=> max_fixed >= $past(max_fixed));

    assert_bad_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (any_bad && !clear) |=> any_bad);

    assert_page_clear_R9: assert property (@(posedge clk) disable iff (rst)
        clear |=> (max_fixed == '0 && !any_bad));

endmodule

// File: rtl/sector_ecc_tracker.sv
module sector_ecc_tracker
    import ecc_stat_pkg::*;
#(
    parameter int SECT_LOG2   = 9,
    localparam int MAX_SECTORS = 1 << (BASE_PAGE_LOG2 + 3 - SECT_LOG2),
    localparam int SIDX_W      = $clog2(MAX_SECTORS),
    localparam int SCNT_W      = SIDX_W + 1,
    localparam int WORDS       = MAX_SECTORS / FIELDS_PER_WORD,
    localparam int WIDX_W      = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               page_start,
    input  logic [1:0]         page_code,
    input  logic               res_valid,
    input  logic [SIDX_W-1:0]  res_sector,
    input  logic [1:0]         res_outcome,
    input  logic [COUNT_W-1:0] res_count,
    input  logic               irq_clear,
    input  logic [WIDX_W-1:0]  rd_word_idx,
    output logic [WORD_W-1:0]  rd_word,
    output logic [WIDX_W:0]    live_words,
    output logic               irq_flag,
    output logic [COUNT_W-1:0] max_correctable,
    output logic               page_uncorrectable
);

    logic [SCNT_W-1:0] sector_count;
    logic              accept;
    ecc_outcome_e      outcome;
    sector_field_t     new_field;

    assign outcome   = ecc_outcome_e'(res_outcome);
    assign accept    = res_valid && !page_start && ({1'b0, res_sector} < sector_count);
    assign new_field = make_field(outcome, res_count);

    ecc_page_geometry #(
        .SECT_LOG2 (SECT_LOG2),
        .SCNT_W    (SCNT_W),
        .WIDX_W    (WIDX_W)
    ) i_geometry (
        .clk          (clk),
        .rst          (rst),
        .page_start   (page_start),
        .page_code    (page_code),
        .sector_count (sector_count),
        .live_words   (live_words)
    );

    ecc_status_bank #(
        .MAX_SECTORS (MAX_SECTORS),
        .SIDX_W      (SIDX_W),
        .WORDS       (WORDS),
        .WIDX_W      (WIDX_W)
    ) i_bank (
        .clk        (clk),
        .rst        (rst),
        .clear      (page_start),
        .wr_en      (accept),
        .wr_idx     (res_sector),
        .wr_field   (new_field),
        .rd_idx     (rd_word_idx),
        .live_words (live_words),
        .rd_word    (rd_word)
    );

    ecc_page_summary i_summary (
        .clk       (clk),
        .rst       (rst),
        .clear     (page_start),
        .accept    (accept),
        .outcome   (outcome),
        .nerr      (res_count),
        .irq_clear (irq_clear),
        .irq_flag  (irq_flag),
        .max_fixed (max_correctable),
        .any_bad   (page_uncorrectable)
    );

    assert_ignored_no_irq_R5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !page_start && {1'b0, res_sector} >= sector_count && !irq_flag)
        |=> !irq_flag);

endmodule

// File: tb/test_sector_ecc_tracker.sv
module test_sector_ecc_tracker;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        page_start;
    logic [1:0]  page_code;
    logic        res_valid;
    logic [3:0]  res_sector;
    logic [1:0]  res_outcome;
    logic [4:0]  res_count;
    logic        irq_clear;
    logic [1:0]  rd_word_idx;
    logic [31:0] rd_word;
    logic [2:0]  live_words;
    logic        irq_flag;
    logic [4:0]  max_correctable;
    logic        page_uncorrectable;

    int n_checks = 0;
    int n_errors = 0;

    int m_fld [16];
    int m_code;
    int m_irq;
    int m_max;
    int m_bad;

    always #(CLK_PERIOD/2) clk = ~clk;

    sector_ecc_tracker i_sector_ecc_tracker (
        .clk                (clk),
        .rst                (rst),
        .page_start         (page_start),
        .page_code          (page_code),
        .res_valid          (res_valid),
        .res_sector         (res_sector),
        .res_outcome        (res_outcome),
        .res_count          (res_count),
        .irq_clear          (irq_clear),
        .rd_word_idx        (rd_word_idx),
        .rd_word            (rd_word),
        .live_words         (live_words),
        .irq_flag           (irq_flag),
        .max_correctable    (max_correctable),
        .page_uncorrectable (page_uncorrectable)
    );

    function automatic int nsec(int code);
        return 2 << code;
    endfunction

    function automatic int nlive(int code);
        return (nsec(code) < 4) ? 1 : nsec(code) / 4;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk({tag, " live_words"}, int'(live_words), nlive(m_code));
        chk({tag, " R6 irq_flag"}, int'(irq_flag), m_irq);
        chk({tag, " R7 max_correctable"}, int'(max_correctable), m_max);
        chk({tag, " R8 page_uncorrectable"}, int'(page_uncorrectable), m_bad);
        for (int w = 0; w < 4; w++) begin
            int exp;
            rd_word_idx = 2'(w);
            #1;
            exp = 0;
            if (w < nlive(m_code))
                for (int b = 0; b < 4; b++) exp |= m_fld[4*w + b] << (8*b);
            chk($sformatf("%s R1 R4 word%0d", tag, w), int'(rd_word), exp);
        end
    endtask

    task automatic cyc(string tag, bit ps, int pc, bit v, int s, int o, int c, bit clr);
        page_start  = ps;
        page_code   = 2'(pc);
        res_valid   = v;
        res_sector  = 4'(s);
        res_outcome = 2'(o);
        res_count   = 5'(c);
        irq_clear   = clr;
        @(posedge clk);
        // behavioural model of the requirements
        if (ps) begin
            for (int i = 0; i < 16; i++) m_fld[i] = 0;
            m_max  = 0;
            m_bad  = 0;
            m_code = pc;
            if (clr) m_irq = 0;
        end else if (v && s < nsec(m_code)) begin
            m_fld[s] = (o == 0) ? 0 : ((c << 2) | o);
            if (o == 1 && c > m_max) m_max = c;
            if (o >= 2) m_bad = 1;
            if (o != 0) m_irq = 1;
            else if (clr) m_irq = 0;
        end else if (clr) begin
            m_irq = 0;
        end
        #1;
        page_start = 0; res_valid = 0; irq_clear = 0;
        check_all(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst = 1; page_start = 0; page_code = 0; res_valid = 0; res_sector = 0;
        res_outcome = 0; res_count = 0; irq_clear = 0; rd_word_idx = 0;
        for (int i = 0; i < 16; i++) m_fld[i] = 0;
        m_code = 0; m_irq = 0; m_max = 0; m_bad = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        #1 check_all("R10 reset");

        // R3: 2K page, four sectors, one word
        cyc("R3", 1, 1, 0, 0, 0, 0, 0);
        cyc("R1", 0, 0, 1, 0, 1, 3, 0);
        cyc("R1", 0, 0, 1, 3, 1, 7, 0);
        cyc("R2", 0, 0, 1, 1, 0, 17, 0);            // R2: clean outcome stores zero
        cyc("R5", 0, 0, 1, 4, 2, 9, 0);             // R5: just past the end, ignored
        cyc("R6", 0, 0, 0, 0, 0, 0, 1);             // R6 clear
        cyc("R5", 0, 0, 1, 15, 3, 31, 0);           // R5: no irq from ignored result
        cyc("R8", 0, 0, 1, 2, 2, 4, 0);
        cyc("R6", 0, 0, 1, 1, 1, 2, 1);             // R6: set beats clear
        cyc("R11", 0, 0, 1, 0, 1, 1, 0);            // R11: overwrite sector 0
        // R9: page start with a result in the same cycle, irq kept
        cyc("R9", 1, 0, 1, 0, 3, 5, 0);
        cyc("R4", 0, 0, 1, 1, 1, 12, 0);            // R4: 1K page, two sectors, one word
        cyc("R5", 0, 0, 1, 2, 1, 30, 0);            // R5: sector 2 absent in 1K page
        // 8K page, sixteen sectors
        cyc("R3", 1, 3, 0, 0, 0, 0, 1);
        for (int s = 0; s < 16; s++) cyc("R1", 0, 0, 1, s, 1, s + 1, 0);
        cyc("R7", 0, 0, 1, 9, 1, 2, 0);
        cyc("R3", 1, 2, 0, 0, 0, 0, 0);             // R3: 4K page
        cyc("R5", 0, 0, 1, 8, 1, 6, 0);
        cyc("R4", 0, 0, 1, 7, 3, 8, 0);
        // pseudo-random phase over all codes
        for (int k = 0; k < 400; k++) begin
            if (k % 40 == 0) cyc("R9", 1, $urandom_range(3), 0, 0, 0, 0, 0);
            else cyc("R11", 0, 0, $urandom_range(1), $urandom_range(15),
                     $urandom_range(3), $urandom_range(31), ($urandom_range(7) == 0));
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule